// File: doc/BRIEF.md
# Pre-Trigger Window Capture with Event Queue

The block records three sample channels without pause into one ring memory per channel. A trigger pulse freezes a point in that history. A fixed window of samples, which starts a programmable number of samples before the trigger, is then moved out of all three rings in parallel. It goes into three lane queues, one per channel, which run in lock step. During this transfer the block raises a trigger-inhibit output. It drops the output again as soon as the last sample of the window has landed.

Each completed transfer becomes one event on a 12-bit valid/ready stream. The event starts with three header words: an accepted-event number and a 24-bit timestamp that an external time-stamping unit supplies. The three channel windows follow, one channel after another. The lane queues hold several events, so short bursts of triggers are absorbed while the consumer is slow. A trigger that arrives when the queues cannot take a whole window is refused and counted, so that no partial event is ever stored.

Top module: `pretrig_capture`

## Requirements
- R1: Every clock, one sample per channel is written into that channel's 1024-deep ring. For an accepted trigger, a channel's window is the 500 consecutive samples that begin with the sample presented `pre` cycles before the trigger cycle. With `pre` = 0 the window begins with the sample presented together with the trigger.
- R2: A `pre_cfg` value above 1022 acts exactly as 1022. This keeps the read window from ever meeting the ring's write position.
- R3: `inhibit` goes high in the cycle after an accepted trigger and stays high for exactly 501 cycles. A trigger presented while `inhibit` is high produces no event and leaves `drop_count` unchanged.
- R4: Each event is 1503 words in this order: 3 header words, then the 500 samples of channel 0, then channel 1, then channel 2, each channel's samples oldest first. `ev_last` is high on word 1503 only. Events leave in the order their triggers were accepted.
- R5: Header word 0 is the accepted-event number modulo 4096, counted from 0 after reset. Header word 1 is `ts_in[23:12]` and header word 2 is `ts_in[11:0]`, both sampled in the trigger cycle.
- R6: An idle trigger is refused when any lane queue holds more than 1548 words, or when the header queue is full. A refused trigger increments `drop_count` by one, leaves `inhibit` low and writes nothing.
- R7: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_data` and `ev_last` keep their values into the next cycle.
- R8: After reset, `inhibit` is low, `ev_valid` is low and `drop_count` is zero.
- R9: With the output stalled, four back-to-back events are stored complete (each lane is 2048 deep). A fifth trigger is refused. The space is reclaimed as words leave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample per channel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| samples | input | 3x12 | Current sample of each channel, channel index as the outer dimension |
| trig | input | 1 | Trigger request, sampled each cycle |
| ts_in | input | 24 | Timestamp from the time-stamping unit |
| pre_cfg | input | 10 | Number of samples the window reaches back before the trigger |
| inhibit | output | 1 | High while a window transfer is running |
| ev_valid | output | 1 | Event stream word valid |
| ev_ready | input | 1 | Event stream consumer ready |
| ev_data | output | 12 | Event stream word |
| ev_last | output | 1 | Marks the final word of an event |
| drop_count | output | 16 | Number of refused triggers, wrapping |

## Verification
Two functions can fall in the same cycle: a running window transfer writes samples into a lane queue, and the output side pops older events from that same queue. The bench provokes this by issuing triggers while earlier events are still leaving under a random `ev_ready` pattern. It then judges every delivered word against a sample value that it computes from the cycle at which that sample was presented. A second collision, a trigger in the same cycle as a full queue, is forced by stalling the output until four events are stored. The outcome is judged through `inhibit`, `drop_count` and the number and content of events that appear once the stream resumes.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int SMP_W     = 12;
    localparam int NCH       = 3;
    localparam int TS_W      = 24;
    localparam int HDR_WORDS = 1 + (TS_W + SMP_W - 1) / SMP_W;

    typedef logic [SMP_W-1:0] smp_t;

    typedef struct packed {
        logic [SMP_W-1:0] evnum;
        logic [TS_W-1:0]  ts;
    } hdr_t;

    typedef enum logic [1:0] {
        CP_IDLE,
        CP_READ,
        CP_FLUSH
    } cp_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HDR,
        TX_DATA
    } tx_state_t;

    // Header word idx: 0 carries the event number, then timestamp high to low
    function automatic smp_t hdr_word(hdr_t h, int unsigned idx);
        logic [HDR_WORDS*SMP_W-1:0] flat;
        flat = '0;
        flat[TS_W-1:0] = h.ts;
        flat[HDR_WORDS*SMP_W-1 -: SMP_W] = h.evnum;
        return flat[(HDR_WORDS-1-idx)*SMP_W +: SMP_W];
    endfunction

endpackage

// File: rtl/ptc_ring.sv
module ptc_ring #(
    parameter int DEPTH = 1024,
    parameter int W     = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Unconditional write every cycle; read returns the old word on a clash
    always_ff @(posedge clk) begin
        mem[waddr] <= din;
        rdata      <= mem[raddr];
    end

endmodule

// File: rtl/ptc_fifo.sv
module ptc_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head word is visible without a read request
    assign rdata = mem[rp];

    // R6: the admission test must keep every push inside the queue
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CW'(DEPTH)))
        else $error("queue written while full");

    // R4: the transmitter only pops words of a completed event
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0))
        else $error("queue read while empty");

endmodule

// File: rtl/ptc_copy_ctrl.sv
module ptc_copy_ctrl
    import ptc_pkg::*;
#(
    parameter int RING_DEPTH = 1024,
    parameter int WINDOW     = 500,
    localparam int AW        = $clog2(RING_DEPTH),
    localparam int WCW       = $clog2(WINDOW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig,
    input  logic [TS_W-1:0] ts_in,
    input  logic [AW-1:0]   pre,
    input  logic            room,
    output logic [AW-1:0]   waddr,
    output logic [AW-1:0]   raddr,
    output logic            lane_we,
    output logic            hdr_push,
    output hdr_t            hdr_out,
    output logic            inhibit,
    output logic [15:0]     drop_count
);

    localparam logic [AW-1:0] PRE_MAX = AW'(RING_DEPTH - 2);

    cp_state_t      state;
    logic [WCW-1:0] rd_cnt;
    logic [AW-1:0]  pre_eff;
    smp_t           evn;
    logic           accept;
    logic           refuse;

    always_comb begin
        pre_eff  = (pre > PRE_MAX) ? PRE_MAX : pre;
        accept   = trig && (state == CP_IDLE) && room;
        refuse   = trig && (state == CP_IDLE) && !room;
        inhibit  = (state != CP_IDLE);
        hdr_push = (state == CP_FLUSH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CP_IDLE;
            waddr      <= '0;
            raddr      <= '0;
            rd_cnt     <= '0;
            lane_we    <= 1'b0;
            evn        <= '0;
            drop_count <= '0;
            hdr_out    <= '0;
        end else begin
            waddr   <= waddr + 1'b1;
            lane_we <= (state == CP_READ);
            case (state)
                CP_IDLE: begin
                    if (accept) begin
                        state   <= CP_READ;
                        raddr   <= waddr - pre_eff;
                        rd_cnt  <= '0;
                        hdr_out <= '{evnum: evn, ts: ts_in};
                    end
                    if (refuse) begin
                        drop_count <= drop_count + 16'd1;
                    end
                end
                CP_READ: begin
                    raddr  <= raddr + 1'b1;
                    rd_cnt <= rd_cnt + 1'b1;
                    if (rd_cnt == WCW'(WINDOW - 1)) begin
                        state <= CP_FLUSH;
                    end
                end
                CP_FLUSH: begin
                    state <= CP_IDLE;
                    evn   <= evn + 1'b1;
                end
                default: state <= CP_IDLE;
            endcase
        end
    end

    // Checker state: length of the current inhibit run
    logic [WCW+1:0] inh_len;
    always_ff @(posedge clk) begin
        if (rst)          inh_len <= '0;
        else if (inhibit) inh_len <= inh_len + 1'b1;
        else              inh_len <= '0;
    end

    assert_accept_inhibit_R3: assert property (@(posedge clk) disable iff (rst)
        (trig && !inhibit && room) |=> inhibit)
        else $error("accepted trigger did not raise inhibit");

    assert_inhibit_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(inhibit) |-> ($past(inh_len) == (WCW+2)'(WINDOW)))
        else $error("inhibit run length wrong");

    assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (trig && inhibit) |=> (drop_count == $past(drop_count)))
        else $error("trigger during inhibit changed the drop count");

    assert_refuse_count_R6: assert property (@(posedge clk) disable iff (rst)
        (trig && !inhibit && !room) |=> (!inhibit && drop_count == $past(drop_count) + 16'd1))
        else $error("refused trigger handled wrongly");

endmodule

// File: rtl/ptc_event_tx.sv
module ptc_event_tx
    import ptc_pkg::*;
#(
    parameter int WINDOW = 500,
    localparam int CNT_W = $clog2((WINDOW > HDR_WORDS) ? WINDOW : HDR_WORDS),
    localparam int CHW   = $clog2(NCH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hdr_avail,
    input  hdr_t                       hdr,
    input  logic [NCH-1:0][SMP_W-1:0]  lane_data,
    output logic [NCH-1:0]             lane_pop,
    output logic                       hdr_pop,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [SMP_W-1:0]           out_data,
    output logic                       out_last
);

    tx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [CHW-1:0]   ch;
    logic             hs;

    always_comb begin
        out_valid = (state != TX_IDLE);
        hs        = out_valid && out_ready;
        out_last  = (state == TX_DATA) && (ch == CHW'(NCH - 1)) && (cnt == CNT_W'(WINDOW - 1));
        out_data  = '0;
        lane_pop  = '0;
        if (state == TX_HDR) begin
            out_data = hdr_word(hdr, 32'(cnt));
        end else if (state == TX_DATA) begin
            out_data     = lane_data[ch];
            lane_pop[ch] = hs;
        end
        hdr_pop = hs && out_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            cnt   <= '0;
            ch    <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (hdr_avail) begin
                        state <= TX_HDR;
                        cnt   <= '0;
                    end
                end
                TX_HDR: begin
                    if (hs) begin
                        if (cnt == CNT_W'(HDR_WORDS - 1)) begin
                            state <= TX_DATA;
                            cnt   <= '0;
                            ch    <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                TX_DATA: begin
                    if (hs) begin
                        if (cnt == CNT_W'(WINDOW - 1)) begin
                            cnt <= '0;
                            if (ch == CHW'(NCH - 1)) state <= TX_IDLE;
                            else                     ch    <= ch + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
        else $error("stream word changed while stalled");

endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
    import ptc_pkg::*;
#(
    parameter int RING_DEPTH = 1024,
    parameter int WINDOW     = 500,
    parameter int LANE_DEPTH = 2048,
    parameter int HDR_DEPTH  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCH-1:0][SMP_W-1:0] samples,
    input  logic                      trig,
    input  logic [TS_W-1:0]           ts_in,
    input  logic [$clog2(RING_DEPTH)-1:0] pre_cfg,
    output logic                      inhibit,
    output logic                      ev_valid,
    input  logic                      ev_ready,
    output logic [SMP_W-1:0]          ev_data,
    output logic                      ev_last,
    output logic [15:0]               drop_count
);

    localparam int AW  = $clog2(RING_DEPTH);
    localparam int LCW = $clog2(LANE_DEPTH + 1);
    localparam int HCW = $clog2(HDR_DEPTH + 1);
    localparam int HW  = $bits(hdr_t);

    logic [AW-1:0]              waddr;
    logic [AW-1:0]              raddr;
    logic                       lane_we;
    logic                       hdr_push;
    logic                       hdr_pop;
    hdr_t                       hdr_new;
    hdr_t                       hdr_head;
    logic [HW-1:0]              hdr_raw;
    logic [HCW-1:0]             hdr_cnt;
    logic [NCH-1:0][SMP_W-1:0]  ring_q;
    logic [NCH-1:0][SMP_W-1:0]  lane_q;
    logic [NCH-1:0][LCW-1:0]    lane_cnt;
    logic [NCH-1:0]             lane_room;
    logic [NCH-1:0]             lane_pop;
    logic                       room;

    ptc_copy_ctrl #(
        .RING_DEPTH (RING_DEPTH),
        .WINDOW     (WINDOW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .ts_in      (ts_in),
        .pre        (pre_cfg),
        .room       (room),
        .waddr      (waddr),
        .raddr      (raddr),
        .lane_we    (lane_we),
        .hdr_push   (hdr_push),
        .hdr_out    (hdr_new),
        .inhibit    (inhibit),
        .drop_count (drop_count)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ptc_ring #(
            .DEPTH (RING_DEPTH),
            .W     (SMP_W)
        ) u_ring (
            .clk   (clk),
            .waddr (waddr),
            .din   (samples[c]),
            .raddr (raddr),
            .rdata (ring_q[c])
        );

        ptc_fifo #(
            .W     (SMP_W),
            .DEPTH (LANE_DEPTH)
        ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .push  (lane_we),
            .wdata (ring_q[c]),
            .pop   (lane_pop[c]),
            .rdata (lane_q[c]),
            .count (lane_cnt[c])
        );

        assign lane_room[c] = (lane_cnt[c] <= LCW'(LANE_DEPTH - WINDOW));
    end

    ptc_fifo #(
        .W     (HW),
        .DEPTH (HDR_DEPTH)
    ) u_hdrq (
        .clk   (clk),
        .rst   (rst),
        .push  (hdr_push),
        .wdata (hdr_new),
        .pop   (hdr_pop),
        .rdata (hdr_raw),
        .count (hdr_cnt)
    );

    assign hdr_head = hdr_t'(hdr_raw);
    assign room     = (&lane_room) && (hdr_cnt < HCW'(HDR_DEPTH));

    ptc_event_tx #(
        .WINDOW (WINDOW)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .hdr_avail (hdr_cnt != '0),
        .hdr       (hdr_head),
        .lane_data (lane_q),
        .lane_pop  (lane_pop),
        .hdr_pop   (hdr_pop),
        .out_valid (ev_valid),
        .out_ready (ev_ready),
        .out_data  (ev_data),
        .out_last  (ev_last)
    );

endmodule

// File: tb/pretrig_capture_test.sv
module pretrig_capture_test;

    localparam int WIN    = 500;
    localparam int EVLEN  = 3 + 3 * WIN;
    localparam int MAXEV  = 32;

    logic             clk = 1'b0;
    logic             rst;
    logic [2:0][11:0] samples;
    logic             trig;
    logic [23:0]      ts_in;
    logic [9:0]       pre_cfg;
    logic             inhibit;
    logic             ev_valid;
    logic             ev_ready;
    logic [11:0]      ev_data;
    logic             ev_last;
    logic [15:0]      drop_count;

    always #10 clk = ~clk;

    pretrig_capture uut (
        .clk(clk), .rst(rst), .samples(samples), .trig(trig), .ts_in(ts_in),
        .pre_cfg(pre_cfg), .inhibit(inhibit), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_data(ev_data), .ev_last(ev_last), .drop_count(drop_count)
    );

    int unsigned ncyc = 0;
    always @(posedge clk) ncyc <= ncyc + 1;

    function automatic logic [11:0] samp(int unsigned n, int unsigned c);
        int unsigned v;
        v = n * 37 + c * 1361 + (n >> 3) * 5 + (n >> 6) * 11;
        return v[11:0];
    endfunction

    always_comb begin
        for (int c = 0; c < 3; c++) samples[c] = samp(ncyc, c);
    end

    int          tests = 0, fails = 0, ctests = 0, cfails = 0;
    int unsigned e_tn  [MAXEV];
    int unsigned e_pre [MAXEV];
    logic [23:0] e_ts  [MAXEV];
    int          n_exp = 0;
    int          cur_ev = 0;
    int          ready_mode = 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Collector: drives ready, checks every word of every event
    int          widx = 0;
    bit          hold_chk = 0;
    logic [11:0] hold_d;
    logic        hold_l;
    bit          hdr_bad, dat_bad, last_bad;
    int          bad_act, bad_exp, hbad_act, hbad_exp;

    always @(negedge clk) begin
        logic r;
        logic [11:0] expw;
        if (hold_chk) begin
            ctests++;
            if (!ev_valid || ev_data !== hold_d || ev_last !== hold_l) begin
                cfails++;
                $display("FAIL R7 actual=%0d expected=%0d", ev_data, hold_d);
            end
        end
        case (ready_mode)
            0:       r = 1'b0;
            1:       r = 1'b1;
            default: r = 1'($urandom % 2);
        endcase
        ev_ready = r;
        if (!rst && ev_valid && r) begin
            if (cur_ev >= n_exp || cur_ev >= MAXEV) begin
                ctests++; cfails++;
                $display("FAIL R4 actual=%0d expected=%0d (unexpected event)", cur_ev + 1, n_exp);
                cur_ev++;
            end else begin
                if (widx == 0) begin
                    hdr_bad = 0; dat_bad = 0; last_bad = 0;
                end
                if (widx < 3) begin
                    if (widx == 0)      expw = 12'(cur_ev);
                    else if (widx == 1) expw = e_ts[cur_ev][23:12];
                    else                expw = e_ts[cur_ev][11:0];
                    if (ev_data !== expw && !hdr_bad) begin
                        hdr_bad = 1; hbad_act = ev_data; hbad_exp = expw;
                    end
                end else begin
                    int unsigned j, chn, k;
                    j = widx - 3; chn = j / WIN; k = j % WIN;
                    expw = samp(e_tn[cur_ev] - e_pre[cur_ev] + k, chn);
                    if (ev_data !== expw && !dat_bad) begin
                        dat_bad = 1; bad_act = ev_data; bad_exp = expw;
                    end
                end
                if (ev_last !== (widx == EVLEN - 1)) last_bad = 1;
                widx++;
                if (widx == EVLEN) begin
                    ctests += 3;
                    if (hdr_bad) begin
                        cfails++;
                        $display("FAIL R5 event %0d header actual=%0d expected=%0d", cur_ev, hbad_act, hbad_exp);
                    end
                    if (dat_bad) begin
                        cfails++;
                        $display("FAIL R1 event %0d sample actual=%0d expected=%0d", cur_ev, bad_act, bad_exp);
                    end
                    if (last_bad) begin
                        cfails++;
                        $display("FAIL R4 event %0d last flag actual=0 expected=1", cur_ev);
                    end
                    widx = 0;
                    cur_ev++;
                end
            end
        end
        hold_chk = ev_valid && !r && !rst;
        hold_d   = ev_data;
        hold_l   = ev_last;
    end

    task automatic fire(input int unsigned pre, input logic [23:0] ts, input bit expect_ok);
        @(negedge clk);
        trig    = 1'b1;
        pre_cfg = pre[9:0];
        ts_in   = ts;
        if (expect_ok && n_exp < MAXEV) begin
            e_tn[n_exp]  = ncyc;
            e_pre[n_exp] = (pre > 1022) ? 1022 : pre;
            e_ts[n_exp]  = ts;
            n_exp++;
        end
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (inhibit && t < 2000) begin @(negedge clk); t++; end
    endtask

    task automatic wait_drain();
        int t = 0;
        while (cur_ev < n_exp && t < 40000) begin @(negedge clk); t++; end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests + ctests, fails + cfails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cur_ev, n_exp);
        finish_run();
    end

    initial begin
        int len;
        void'($urandom(32'd5150));
        rst = 1'b1; trig = 1'b0; ts_in = '0; pre_cfg = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(inhibit == 1'b0, "R8 inhibit", inhibit, 0);
        check(ev_valid == 1'b0, "R8 valid", ev_valid, 0);
        check(drop_count == 16'd0, "R8 drops", drop_count, 0);
        repeat (1100) @(negedge clk);

        // Directed: inhibit length and a trigger during inhibit
        ready_mode = 1;
        fire(100, 24'h00A5C3, 1);
        check(inhibit == 1'b1, "R3 inhibit rise", inhibit, 1);
        len = 0;
        while (inhibit && len < 2000) begin
            len++;
            trig = (len == 10);
            @(negedge clk);
        end
        trig = 1'b0;
        check(len == WIN + 1, "R3 inhibit length", len, WIN + 1);
        check(drop_count == 16'd0, "R3 busy trigger not counted", drop_count, 0);
        wait_drain();
        check(cur_ev == 1, "R3 busy trigger gave no event", cur_ev, 1);

        // Directed: window offset corners (R1, R2)
        fire(0, 24'h123456, 1);    wait_idle();
        fire(1022, 24'hFEDCBA, 1); wait_idle();
        fire(1023, 24'h0F0F0F, 1); wait_idle();
        wait_drain();
        check(cur_ev == 4, "R2 clamped offset events", cur_ev, 4);

        // Stalled output: four stored, fifth refused (R6, R9)
        ready_mode = 0;
        for (int i = 0; i < 4; i++) begin
            fire($urandom % 1023, 24'($urandom), 1);
            wait_idle();
        end
        fire(50, 24'h777777, 0);
        check(inhibit == 1'b0, "R6 refused trigger keeps inhibit low", inhibit, 0);
        check(drop_count == 16'd1, "R6 drop count", drop_count, 1);
        repeat (20) @(negedge clk);
        check(inhibit == 1'b0, "R6 nothing copied", inhibit, 0);
        ready_mode = 2;
        wait_drain();
        check(cur_ev == 8, "R9 four stored events delivered", cur_ev, 8);
        fire(7, 24'h0000FF, 1);
        check(inhibit == 1'b1, "R9 space reclaimed", inhibit, 1);
        wait_idle();

        // Random offsets, timestamps and gaps under random backpressure
        for (int i = 0; i < 6; i++) begin
            int t = 0;
            while ((n_exp - cur_ev) > 2 && t < 20000) begin @(negedge clk); t++; end
            repeat ($urandom % 300) @(negedge clk);
            fire($urandom % 1024, 24'($urandom), 1);
            wait_idle();
        end
        wait_drain();
        check(cur_ev == n_exp, "R4 all events delivered in order", cur_ev, n_exp);
        check(drop_count == 16'd1, "R6 no extra drops", drop_count, 1);
        repeat (10) @(negedge clk);
        check(ev_valid == 1'b0, "R4 stream idle after last event", ev_valid, 0);
        finish_run();
    end

endmodule